// File: doc/BRIEF.md
# Bidirectional Parallel Port Pair with Edge-Triggered Interrupt

This block is a register-mapped peripheral for a small 8-bit processor bus. It provides two 8-bit ports, A and B. Each pin of each port is an output or an input according to its own direction bit. A read of a port data register merges the two cases: pins set as outputs return the value last written, and pins set as inputs return the level at the pin.

Each port has a first control line, which is an input sensed for an edge, and a second control line, which can be driven as a static output. A control register picks the active edge of each first control line and the mode of each second control line. An active edge latches a per-line flag. Any latched flag whose enable bit is set pulls the active-low interrupt request low. An access to a port's data register clears that port's flag.

The enable register uses a set/clear write protocol, so software can change one source without a read-modify-write. The register bus is a plain single-cycle interface with no back-pressure: every access completes in the cycle it is presented. Read data is combinational from the address.

Top module: `pport_edge_irq`

## Requirements
- R1: After reset the data and direction registers are 0, both `pa_oe` and `pb_oe` are 0, the control register reads 0x00, the enable register reads 0x80, both second-line `*_oe` outputs are 0, and `irq_n` is 1.
- R2: With `sel` high, the register offsets on `addr` are: 0x0 port B data, 0x1 port A data, 0x2 port B direction, 0x3 port A direction, 0xC control, 0xE enable. A write to any other offset changes nothing, and a read of any other offset returns 0x00.
- R3: A direction bit of 1 makes the matching pin an output, and `p*_oe` equals the direction register. `p*_out` always shows the port's output register, which changes only on a write to that port's data offset.
- R4: A data read returns the output-register bit for each pin whose direction bit is 1, and the input-pin level for each pin whose direction bit is 0.
- R5: A write to the enable register with bit 7 = 1 sets every enable bit whose `wdata` bit (6..0) is 1. With bit 7 = 0 it clears every such enable bit. All other enable bits keep their value. A read returns bit 7 as 1 and the enable bits in bits 6..0.
- R6: Control bit 0 selects the edge of `line1_a_in` and control bit 4 selects the edge of `line1_b_in`: 0 means falling and 1 means rising. Each input passes through two synchronizer flops. The line's flag is set at the third rising clock edge after the input changes.
- R7: `irq_n` is 0 exactly when (port A flag AND enable bit 1) OR (port B flag AND enable bit 4). A flag is latched even while its enable bit is 0, and it asserts `irq_n` as soon as the enable is set.
- R8: A read or write of offset 0x1 clears the port A flag, and a read or write of offset 0x0 clears the port B flag. An access to one port's data does not clear the other port's flag. If an active edge arrives in the same cycle as a clearing access, the edge wins.
- R9: Control bits 3..1 set the port A second line and bits 7..5 set the port B second line. Mode 110 drives the line low (oe=1, out=0). Mode 111 drives it high (oe=1, out=1). Every other mode gives oe=0 and out=0.
- R10: An edge of the opposite polarity to the one selected sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Peripheral select |
| rd_en | input | 1 | Read strobe, qualified by sel |
| wr_en | input | 1 | Write strobe, qualified by sel |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data; 0 when no read is active |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output register |
| pa_oe | output | 8 | Port A per-pin output enable |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output register |
| pb_oe | output | 8 | Port B per-pin output enable |
| line1_a_in | input | 1 | Port A edge-sensed control line |
| line1_b_in | input | 1 | Port B edge-sensed control line |
| line2_a_out | output | 1 | Port A second control line level |
| line2_a_oe | output | 1 | Port A second control line drive enable |
| line2_b_out | output | 1 | Port B second control line level |
| line2_b_oe | output | 1 | Port B second control line drive enable |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench reads ports with mixed direction masks. A design that took every bit from the register, or every bit from the pin, would return the wrong nibble. It writes the enable register with bit 7 both set and clear, and checks that only the named bits move. A design that overwrote the whole register would lose the other source's enable. The bench also checks each edge in both polarities and measures the flag latency cycle by cycle. This catches a design that ignores the edge select, reacts to both edges, or has the wrong synchronizer depth. Finally, it latches a flag while its enable is off and clears flags through the other port's data register. A design that gated the flag itself with the enable, or cleared both flags on any access, would show the wrong `irq_n`.

// File: rtl/pport_pkg.sv
package pport_pkg;
  localparam int OFF_PB_DATA = 'h0;
  localparam int OFF_PA_DATA = 'h1;
  localparam int OFF_PB_DIR  = 'h2;
  localparam int OFF_PA_DIR  = 'h3;
  localparam int OFF_CTRL    = 'hC;
  localparam int OFF_IEN     = 'hE;
  // enable bit for each edge line: index 0 = port A, 1 = port B
  localparam int IEN_BIT_A   = 1;
  localparam int IEN_BIT_B   = 4;
endpackage

// File: rtl/pport_dirport.sv
module pport_dirport #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_data,
  input  logic         wr_dir,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] rd_val
);
  logic [W-1:0] out_q, dir_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q <= '0;
      dir_q <= '0;
    end else begin
      if (wr_data) out_q <= wdata;
      if (wr_dir)  dir_q <= wdata;
    end
  end

  // per-pin readback source: driven pins report the register, others the pin
  for (genvar i = 0; i < W; i++) begin : g_rb
    assign rd_val[i] = dir_q[i] ? out_q[i] : pin_in[i];
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
endmodule

// File: rtl/pport_edge_flag.sv
module pport_edge_flag #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  input  logic rise_sel,
  input  logic clr,
  output logic flag,
  output logic pulse
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], line_in};
      prev_q <= sync_q[STAGES-1];
      if (pulse)    flag_q <= 1'b1;   // edge has priority over clear
      else if (clr) flag_q <= 1'b0;
    end
  end

  assign pulse = rise_sel ? ( sync_q[STAGES-1] & ~prev_q)
                          : (~sync_q[STAGES-1] &  prev_q);
  assign flag  = flag_q;
endmodule

// File: rtl/pport_ien.sv
module pport_ien #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-2:0] en
);
  logic [W-2:0] en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= '0;
    else if (wr) begin
      if (wdata[W-1]) en_q <= en_q |  wdata[W-2:0];
      else            en_q <= en_q & ~wdata[W-2:0];
    end
  end

  assign en = en_q;
endmodule

// File: rtl/pport_edge_irq.sv
module pport_edge_irq
  import pport_pkg::*;
#(
  parameter int DW          = 8,
  parameter int AW          = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] pa_in,
  output logic [DW-1:0] pa_out,
  output logic [DW-1:0] pa_oe,
  input  logic [DW-1:0] pb_in,
  output logic [DW-1:0] pb_out,
  output logic [DW-1:0] pb_oe,
  input  logic          line1_a_in,
  input  logic          line1_b_in,
  output logic          line2_a_out,
  output logic          line2_a_oe,
  output logic          line2_b_out,
  output logic          line2_b_oe,
  output logic          irq_n
);
  localparam int NLINE = 2;
  localparam int LANE  = DW / NLINE;  // control-register bits per line

  logic acc, wr_q;
  logic hit_pa, hit_pb, hit_pa_dir, hit_pb_dir, hit_ctrl, hit_ien;
  logic [DW-1:0] ctrl_q;
  logic [DW-2:0] ien_q;
  logic [DW-1:0] pa_rd, pb_rd;
  logic [NLINE-1:0] line_in, clr, flag_q, pulse, l2_out, l2_oe, line_en;

  assign acc        = sel & (rd_en | wr_en);
  assign wr_q       = sel & wr_en;
  assign hit_pa     = addr == AW'(OFF_PA_DATA);
  assign hit_pb     = addr == AW'(OFF_PB_DATA);
  assign hit_pa_dir = addr == AW'(OFF_PA_DIR);
  assign hit_pb_dir = addr == AW'(OFF_PB_DIR);
  assign hit_ctrl   = addr == AW'(OFF_CTRL);
  assign hit_ien    = addr == AW'(OFF_IEN);

  pport_dirport #(.W(DW)) u_port_a (
    .clk(clk), .rst_n(rst_n),
    .wr_data(wr_q & hit_pa), .wr_dir(wr_q & hit_pa_dir),
    .wdata(wdata), .pin_in(pa_in),
    .pin_out(pa_out), .pin_oe(pa_oe), .rd_val(pa_rd)
  );

  pport_dirport #(.W(DW)) u_port_b (
    .clk(clk), .rst_n(rst_n),
    .wr_data(wr_q & hit_pb), .wr_dir(wr_q & hit_pb_dir),
    .wdata(wdata), .pin_in(pb_in),
    .pin_out(pb_out), .pin_oe(pb_oe), .rd_val(pb_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= '0;
    else if (wr_q & hit_ctrl) ctrl_q <= wdata;
  end

  pport_ien #(.W(DW)) u_ien (
    .clk(clk), .rst_n(rst_n),
    .wr(wr_q & hit_ien), .wdata(wdata), .en(ien_q)
  );

  assign line_in = {line1_b_in, line1_a_in};
  assign clr     = {acc & hit_pb, acc & hit_pa};
  assign line_en = {ien_q[IEN_BIT_B], ien_q[IEN_BIT_A]};

  for (genvar k = 0; k < NLINE; k++) begin : g_line
    logic [2:0] mode;
    assign mode = ctrl_q[k*LANE+3 -: 3];

    pport_edge_flag #(.STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n),
      .line_in(line_in[k]), .rise_sel(ctrl_q[k*LANE]),
      .clr(clr[k]), .flag(flag_q[k]), .pulse(pulse[k])
    );

    assign l2_oe[k]  = mode[2] & mode[1];
    assign l2_out[k] = mode[2] & mode[1] & mode[0];
  end

  assign line2_a_out = l2_out[0];
  assign line2_a_oe  = l2_oe[0];
  assign line2_b_out = l2_out[1];
  assign line2_b_oe  = l2_oe[1];
  assign irq_n       = ~|(flag_q & line_en);

  always_comb begin
    rdata = '0;
    if (sel & rd_en) begin
      if      (hit_pb)     rdata = pb_rd;
      else if (hit_pa)     rdata = pa_rd;
      else if (hit_pb_dir) rdata = pb_oe;
      else if (hit_pa_dir) rdata = pa_oe;
      else if (hit_ctrl)   rdata = ctrl_q;
      else if (hit_ien)    rdata = {1'b1, ien_q};
    end
  end
endmodule

// File: rtl/pport_edge_irq_chk.sv
module pport_edge_irq_chk #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sel,
  input logic          rd_en,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] pa_out,
  input logic [DW-2:0] ien_q,
  input logic [1:0]    flag_q,
  input logic [1:0]    pulse,
  input logic          irq_n
);
  logic acc, ien_wr;
  assign acc    = sel & (rd_en | wr_en);
  assign ien_wr = sel & wr_en & (addr == AW'('hE));

  // R3: port A output register moves only on a write to offset 1
  p_pa_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && wr_en && addr == AW'('h1)) |=> $stable(pa_out));

  // R5: set form turns on every named bit
  p_ien_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_wr && wdata[DW-1]) |=> ((ien_q & $past(wdata[DW-2:0])) == $past(wdata[DW-2:0])));

  // R5: clear form turns off every named bit
  p_ien_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_wr && !wdata[DW-1]) |=> ((ien_q & $past(wdata[DW-2:0])) == '0));

  // R7: a pending request persists until a data access or enable write
  p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !(acc && (addr == AW'('h0) || addr == AW'('h1) || addr == AW'('hE))))
      |=> !irq_n);

  // R8: access to port A data clears its flag unless an edge coincides
  p_clr_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && addr == AW'('h1) && !pulse[0]) |=> !flag_q[0]);

  // R8: edge wins over a simultaneous clear
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pulse[1] |=> flag_q[1]);
endmodule

bind pport_edge_irq pport_edge_irq_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .rd_en(rd_en), .wr_en(wr_en),
  .addr(addr), .wdata(wdata), .pa_out(pa_out), .ien_q(ien_q),
  .flag_q(flag_q), .pulse(pulse), .irq_n(irq_n)
);

// File: tb/pport_edge_irq_test.sv
module pport_edge_irq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] pa_in = 8'hA5, pb_in = 8'h3C;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe;
  logic       line1_a_in = 1'b1, line1_b_in = 1'b0;
  logic       line2_a_out, line2_a_oe, line2_b_out, line2_b_oe, irq_n;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  pport_edge_irq uut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .line1_a_in(line1_a_in), .line1_b_in(line1_b_in),
    .line2_a_out(line2_a_out), .line2_a_oe(line2_a_oe),
    .line2_b_out(line2_b_out), .line2_b_oe(line2_b_oe), .irq_n(irq_n)
  );

  // vector: {is_write, req, addr, data, expected read}
  localparam int NVEC = 17;
  localparam logic [24:0] VEC [NVEC] = '{
    {1'b1, 4'd3, 4'h3, 8'hF0, 8'h00},
    {1'b1, 4'd3, 4'h1, 8'h5A, 8'h00},
    {1'b0, 4'd4, 4'h1, 8'h00, 8'h55},
    {1'b1, 4'd3, 4'h2, 8'h0F, 8'h00},
    {1'b1, 4'd3, 4'h0, 8'hC3, 8'h00},
    {1'b0, 4'd4, 4'h0, 8'h00, 8'h33},
    {1'b0, 4'd2, 4'h2, 8'h00, 8'h0F},
    {1'b0, 4'd2, 4'h3, 8'h00, 8'hF0},
    {1'b1, 4'd5, 4'hE, 8'h92, 8'h00},
    {1'b0, 4'd5, 4'hE, 8'h00, 8'h92},
    {1'b1, 4'd5, 4'hE, 8'h10, 8'h00},
    {1'b0, 4'd5, 4'hE, 8'h00, 8'h82},
    {1'b1, 4'd2, 4'hC, 8'hCC, 8'h00},
    {1'b0, 4'd2, 4'hC, 8'h00, 8'hCC},
    {1'b1, 4'd2, 4'h5, 8'hFF, 8'h00},
    {1'b0, 4'd2, 4'h5, 8'h00, 8'h00},
    {1'b0, 4'd2, 4'h3, 8'h00, 8'hF0}
  };

  function automatic string rtag(input logic [3:0] n);
    case (n)
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      default: return "R?";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; rd_en = 1'b1; addr = a;
    #5 d = rdata;
    @(negedge clk);
    sel = 1'b0; rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    chk("R1 pa_oe", pa_oe, 8'h00);
    chk("R1 pb_oe", pb_oe, 8'h00);
    chk("R1 pa_out", pa_out, 8'h00);
    chk("R1 irq_n", {7'd0, irq_n}, 8'h01);
    chk("R1 line2 oe", {6'd0, line2_a_oe, line2_b_oe}, 8'h00);
    bus_rd(4'hE, d); chk("R1 ien", d, 8'h80);
    bus_rd(4'hC, d); chk("R1 ctrl", d, 8'h00);
    bus_rd(4'h0, d); chk("R4 pins at reset", d, 8'h3C);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][24]) bus_wr(VEC[i][19:16], VEC[i][15:8]);
      else begin
        bus_rd(VEC[i][19:16], d);
        chk(rtag(VEC[i][23:20]), d, VEC[i][7:0]);
      end
    end

    // R3 pins reflect registers
    chk("R3 pa_oe", pa_oe, 8'hF0);
    chk("R3 pa_out", pa_out, 8'h5A);
    chk("R3 pb_oe", pb_oe, 8'h0F);
    chk("R3 pb_out", pb_out, 8'hC3);

    // R9 second-line modes
    chk("R9 ctrl CC", {4'd0, line2_a_oe, line2_a_out, line2_b_oe, line2_b_out}, 8'b1010);
    bus_wr(4'hC, 8'hEE);
    chk("R9 ctrl EE", {4'd0, line2_a_oe, line2_a_out, line2_b_oe, line2_b_out}, 8'b1111);
    bus_wr(4'hC, 8'h44);
    chk("R9 ctrl 44", {4'd0, line2_a_oe, line2_a_out, line2_b_oe, line2_b_out}, 8'b0000);
    bus_wr(4'hC, 8'hCC);

    // R6 falling edge latency on line A (enable bit 1 already set)
    @(negedge clk); line1_a_in = 1'b0;
    idle(2); chk("R6 no flag before third edge", {7'd0, irq_n}, 8'h01);
    idle(1); chk("R6 falling edge flag", {7'd0, irq_n}, 8'h00);
    bus_rd(4'h1, d);
    chk("R8 read port A clears", {7'd0, irq_n}, 8'h01);
    @(negedge clk); line1_a_in = 1'b1;
    idle(4); chk("R10 rising ignored when falling selected", {7'd0, irq_n}, 8'h01);

    // rising edge selected
    bus_wr(4'hC, 8'h01);
    @(negedge clk); line1_a_in = 1'b0;
    idle(4); chk("R10 falling ignored when rising selected", {7'd0, irq_n}, 8'h01);
    @(negedge clk); line1_a_in = 1'b1;
    idle(3); chk("R6 rising edge flag", {7'd0, irq_n}, 8'h00);
    bus_rd(4'h1, d);
    chk("R8 read clears again", {7'd0, irq_n}, 8'h01);

    // R7 masked flag latches, appears on enable
    bus_wr(4'hE, 8'h02);
    @(negedge clk); line1_a_in = 1'b0;
    idle(4);
    @(negedge clk); line1_a_in = 1'b1;
    idle(4); chk("R7 masked flag hidden", {7'd0, irq_n}, 8'h01);
    bus_wr(4'hE, 8'h82);
    chk("R7 enable exposes latched flag", {7'd0, irq_n}, 8'h00);
    bus_wr(4'h1, 8'h5A);
    chk("R8 write port A clears", {7'd0, irq_n}, 8'h01);

    // port B line, enable bit 4, rising
    bus_wr(4'hE, 8'h90);
    bus_wr(4'hC, 8'h10);
    @(negedge clk); line1_b_in = 1'b1;
    idle(4); chk("R7 port B flag asserts", {7'd0, irq_n}, 8'h00);
    bus_rd(4'h1, d);
    chk("R8 port A access keeps B flag", {7'd0, irq_n}, 8'h00);
    bus_rd(4'h0, d);
    chk("R8 port B read clears", {7'd0, irq_n}, 8'h01);
    chk("R3 pa_out unchanged", pa_out, 8'h5A);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule